// File: doc/BRIEF.md
# Multicycle Processor Hardwired Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. On every cycle it looks at its 4-bit state, the 6-bit opcode held in the instruction register and the ALU zero flag. From these it drives the enables and multiplexer selects of the datapath. Every instruction passes through a shared fetch step and a shared decode/register-read step. The opcode then picks a short tail: jump and branch-equal finish in 3 cycles, R-type and store in 4, and load in 5.

The next state depends only on the current state and the opcode. The control outputs depend only on the state. The one exception is `pc_load`, the combined PC enable, which also looks at the zero flag. The datapath itself is not part of the block. A behavioural model in the bench follows the control words and checks them.

Reset is asynchronous and active low, and it is released synchronously. For one cycle after release the block holds the fetch state with every output quiet. Sequencing then starts.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge after it goes high, every output is 0. After that edge the fetch control word appears.
- R2: The fetch cycle drives `pc_wr`=1, `ir_wr`=1, `mem_rd`=1, `i_or_d`=0, `alu_src_a`=0, `alu_src_b`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00. In this and every other state, controls not listed are 0.
- R3: The decode cycle always follows fetch. It drives `alu_src_a`=0, `alu_src_b`=11 (sign-extended immediate shifted left by 2), `alu_op`=00 and `ext_op`=1, so the branch target is computed ahead of time.
- R4: Opcode 100011 (load) runs through five steps: fetch, decode, address (`alu_src_a`=1, `alu_src_b`=10 extended immediate, `alu_op`=00, `ext_op`=1), read (`mem_rd`=1, `i_or_d`=1), and write-back (`reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0).
- R5: Opcode 101011 (store) runs through four steps: fetch, decode, the same address step as load, then write (`mem_wr`=1, `i_or_d`=1).
- R6: Opcode 000000 (R-type) runs through four steps: fetch, decode, execute (`alu_src_a`=1, `alu_src_b`=00 register B, `alu_op`=10 function field), then completion (`reg_wr`=1, `reg_dst`=1, `mem_to_reg`=0).
- R7: Opcode 000100 (branch-equal) runs through three steps. Its third step drives `alu_src_a`=1, `alu_src_b`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (the stored target).
- R8: Opcode 000010 (jump) runs through three steps. Its third step drives `pc_wr`=1 and `pc_src`=10 (upper PC bits joined with the 26-bit target and two zero bits).
- R9: Any other opcode returns from decode straight to fetch, so that instruction lasts 2 cycles.
- R10: `ir_wr` is 1 only in the fetch cycle, so the instruction register holds steady until the instruction ends.
- R11: `pc_load` equals `pc_wr` OR (`pc_wr_cond` AND `alu_zero`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if zero flag set |
| pc_load | output | 1 | Combined PC enable |
| ir_wr | output | 1 | Instruction register write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| i_or_d | output | 1 | Memory address select: 0 PC, 1 ALU out |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination select: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data select: 0 ALU out, 1 memory data |
| ext_op | output | 1 | Sign-extend the immediate |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B: 00 reg B, 01 four, 10 imm, 11 imm<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | 00 ALU result, 01 ALU out, 10 jump target |

## Verification
Directed instructions come first: one of each opcode class, branch-equal with the zero flag both set and clear, and an undefined opcode. Together these show that each tail has its own control words and its own length. Then hundreds of instructions are drawn at random, mostly valid with some undefined, while the zero flag changes every cycle. These catch wrong next-state decoding, a `pc_load` that ignores or misuses the flag, and instruction-register writes outside fetch. Instruction length is measured from the gap between `ir_wr` pulses. A reset asserted in the middle of a load checks that every output goes quiet and that fetch restarts.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_RDMEM  = 4'd3,
    S_LDWB   = 4'd4,
    S_WRMEM  = 4'd5,
    S_REXE   = 4'd6,
    S_RDONE  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } state_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       i_or_d;
    logic       reg_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       ext_op;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctrl_t;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMM4 = 2'b11;
  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNC  = 2'b10;
  localparam logic [1:0] PCS_ALU   = 2'b00;
  localparam logic [1:0] PCS_OUT   = 2'b01;
  localparam logic [1:0] PCS_JMP   = 2'b10;
endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
  input  state_t            cur_st,
  input  logic [OP_W-1:0]   opcode,
  output state_t            nxt_st
);
  always_comb begin
    nxt_st = S_FETCH;
    unique case (cur_st)
      S_FETCH:  nxt_st = S_DECODE;
      S_DECODE: begin
        if      (opcode == OP_LOAD)  nxt_st = S_ADDR;
        else if (opcode == OP_STORE) nxt_st = S_ADDR;
        else if (opcode == OP_RTYPE) nxt_st = S_REXE;
        else if (opcode == OP_BEQ)   nxt_st = S_BRANCH;
        else if (opcode == OP_JUMP)  nxt_st = S_JUMP;
        else                         nxt_st = S_FETCH;
      end
      S_ADDR:   nxt_st = (opcode == OP_STORE) ? S_WRMEM : S_RDMEM;
      S_RDMEM:  nxt_st = S_LDWB;
      S_REXE:   nxt_st = S_RDONE;
      default:  nxt_st = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  state_t cur_st,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur_st)
      S_FETCH: begin
        ctl.pc_wr     = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.alu_src_b = SRCB_FOUR;
        ctl.alu_op    = ALU_ADD;
        ctl.pc_src    = PCS_ALU;
      end
      S_DECODE: begin
        ctl.alu_src_b = SRCB_IMM4;
        ctl.ext_op    = 1'b1;
      end
      S_ADDR: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_IMM;
        ctl.ext_op    = 1'b1;
      end
      S_RDMEM: begin
        ctl.mem_rd = 1'b1;
        ctl.i_or_d = 1'b1;
      end
      S_LDWB: begin
        ctl.reg_wr     = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      S_WRMEM: begin
        ctl.mem_wr = 1'b1;
        ctl.i_or_d = 1'b1;
      end
      S_REXE: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SRCB_REG;
        ctl.alu_op    = ALU_FUNC;
      end
      S_RDONE: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_src_a  = 1'b1;
        ctl.alu_op     = ALU_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_OUT;
      end
      S_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_zero,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            pc_load,
  output logic            ir_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            i_or_d,
  output logic            reg_wr,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            ext_op,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      alu_op,
  output logic [1:0]      pc_src
);
  state_t st_q, st_d;
  logic   live_q;
  ctrl_t  ctl_raw, ctl;

  mcc_next_state #(.OP_W(OP_W)) u_ns (
    .cur_st (st_q),
    .opcode (opcode),
    .nxt_st (st_d)
  );

  mcc_out_decode u_od (
    .cur_st (st_q),
    .ctl    (ctl_raw)
  );

  // run flag: clears asynchronously, sets on the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // state register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= S_FETCH;
    else if (live_q) st_q <= st_d;
  end

  assign ctl = live_q ? ctl_raw : '0;

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign ir_wr      = ctl.ir_wr;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign i_or_d     = ctl.i_or_d;
  assign reg_wr     = ctl.reg_wr;
  assign reg_dst    = ctl.reg_dst;
  assign mem_to_reg = ctl.mem_to_reg;
  assign ext_op     = ctl.ext_op;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
  assign pc_load    = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (ext_op && alu_src_b == SRCB_IMM4 && !ir_wr)); // R3
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && i_or_d) |=> (reg_wr && mem_to_reg && !reg_dst)); // R4
  AST_RTYPE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_dst) |=> ir_wr); // R6
  AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr); // R7
  AST_JUMP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == PCS_JMP) |=> ir_wr); // R8
  AST_STORE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (ir_wr && !mem_wr)); // R5
endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] OP_R = 6'b000000, OP_LW = 6'b100011, OP_SW = 6'b101011,
                         OP_BEQ = 6'b000100, OP_J = 6'b000010, OP_BAD = 6'b111111;
  // bench-private step codes
  localparam int T_IF = 0, T_ID = 1, T_AD = 2, T_RD = 3, T_WB = 4,
                 T_WR = 5, T_EX = 6, T_RC = 7, T_BR = 8, T_JP = 9;

  logic clk = 1'b0, rst_n;
  logic [5:0] opcode;
  logic alu_zero;
  logic pc_wr, pc_wr_cond, pc_load, ir_wr, mem_rd, mem_wr, i_or_d, reg_wr;
  logic reg_dst, mem_to_reg, ext_op, alu_src_a;
  logic [1:0] alu_src_b, alu_op, pc_src;

  int checks = 0, errors = 0;
  int exp_st;
  int run_len;
  logic [5:0] len_op;
  bit have_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load), .ir_wr(ir_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .i_or_d(i_or_d), .reg_wr(reg_wr),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .ext_op(ext_op),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_src(pc_src)
  );

  // {pc_wr,pc_wr_cond,ir_wr,mem_rd,mem_wr,i_or_d,reg_wr,reg_dst,mem_to_reg,ext_op,src_a,src_b,op,pc_src}
  function automatic logic [16:0] want_word(int s);
    case (s)
      T_IF: return 17'b1_0_1_1_0_0_0_0_0_0_0_01_00_00;
      T_ID: return 17'b0_0_0_0_0_0_0_0_0_1_0_11_00_00;
      T_AD: return 17'b0_0_0_0_0_0_0_0_0_1_1_10_00_00;
      T_RD: return 17'b0_0_0_1_0_1_0_0_0_0_0_00_00_00;
      T_WB: return 17'b0_0_0_0_0_0_1_0_1_0_0_00_00_00;
      T_WR: return 17'b0_0_0_0_1_1_0_0_0_0_0_00_00_00;
      T_EX: return 17'b0_0_0_0_0_0_0_0_0_0_1_00_10_00;
      T_RC: return 17'b0_0_0_0_0_0_1_1_0_0_0_00_00_00;
      T_BR: return 17'b0_1_0_0_0_0_0_0_0_0_1_00_01_01;
      T_JP: return 17'b1_0_0_0_0_0_0_0_0_0_0_00_00_10;
      default: return 17'b0;
    endcase
  endfunction

  function automatic string req_tag(int s);
    case (s)
      T_IF: return "R2";
      T_ID: return "R3";
      T_AD, T_RD, T_WB: return "R4";
      T_WR: return "R5";
      T_EX, T_RC: return "R6";
      T_BR: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int step_after(int s, logic [5:0] op);
    case (s)
      T_IF: return T_ID;
      T_ID: begin
        if (op == OP_LW || op == OP_SW) return T_AD;
        if (op == OP_R)   return T_EX;
        if (op == OP_BEQ) return T_BR;
        if (op == OP_J)   return T_JP;
        return T_IF;
      end
      T_AD: return (op == OP_SW) ? T_WR : T_RD;
      T_RD: return T_WB;
      T_EX: return T_RC;
      default: return T_IF;
    endcase
  endfunction

  function automatic int instr_len(logic [5:0] op);
    case (op)
      OP_LW: return 5;
      OP_SW, OP_R: return 4;
      OP_BEQ, OP_J: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [16:0] got_word();
    return {pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, i_or_d, reg_wr, reg_dst,
            mem_to_reg, ext_op, alu_src_a, alu_src_b, alu_op, pc_src};
  endfunction

  task automatic check_quiet(string tag);
    checks++;
    if (got_word() !== 17'b0 || pc_load !== 1'b0) begin
      errors++;
      $display("FAIL %s quiet outputs: got %b/%b expected 0/0", tag, got_word(), pc_load);
    end
  endtask

  // one cycle: check at negedge, then pick inputs for the coming edge
  task automatic step(logic [5:0] next_op, logic z);
    checks++;
    if (got_word() !== want_word(exp_st)) begin
      errors++;
      $display("FAIL %s step %0d: got %b expected %b", req_tag(exp_st), exp_st, got_word(), want_word(exp_st));
    end
    checks++; // R11
    if (pc_load !== (pc_wr | (pc_wr_cond & alu_zero))) begin
      errors++;
      $display("FAIL R11 pc_load: got %b expected %b", pc_load, pc_wr | (pc_wr_cond & alu_zero));
    end
    // R10 / R9: instruction length from ir_wr spacing
    if (ir_wr === 1'b1) begin
      if (have_len) begin
        checks++;
        if (run_len != instr_len(len_op)) begin
          errors++;
          $display("FAIL %s length op=%b: got %0d expected %0d",
                   (instr_len(len_op) == 2) ? "R9" : "R10", len_op, run_len, instr_len(len_op));
        end
      end
      have_len = 1'b1;
      run_len  = 1;
      len_op   = next_op;
    end else begin
      run_len++;
    end
    if (exp_st == T_IF) opcode = next_op;
    alu_zero = z;
    exp_st = step_after(exp_st, opcode);
    @(negedge clk);
  endtask

  task automatic run_instr(logic [5:0] op, logic z);
    step(op, z);
    while (exp_st != T_IF) step(op, z);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check_quiet("R1");
    repeat (2) @(negedge clk);
    check_quiet("R1");
    rst_n = 1'b1;
    #1;
    check_quiet("R1");
    @(negedge clk);
    exp_st   = T_IF;
    have_len = 1'b0;
    run_len  = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ops [6];
    void'($urandom(32'd1234));
    ops[0] = OP_R; ops[1] = OP_LW; ops[2] = OP_SW; ops[3] = OP_BEQ; ops[4] = OP_J; ops[5] = OP_BAD;
    opcode = 6'h3f; alu_zero = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    // directed: one of each class, branch with zero both ways
    run_instr(OP_LW, 1'b0);
    run_instr(OP_SW, 1'b1);
    run_instr(OP_R, 1'b1);
    run_instr(OP_BEQ, 1'b1);
    run_instr(OP_BEQ, 1'b0);
    run_instr(OP_J, 1'b0);
    run_instr(OP_BAD, 1'b1);
    run_instr(6'b001000, 1'b0);
    run_instr(OP_LW, 1'b0);
    // reset in the middle of a load (R1)
    step(OP_LW, 1'b0); step(OP_LW, 1'b0); step(OP_LW, 1'b0);
    do_reset();
    run_instr(OP_J, 1'b1);
    // random run
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      if ($urandom_range(9) == 0) op = 6'($urandom);
      else op = ops[$urandom_range(4)];
      step(op, 1'($urandom));
      while (exp_st != T_IF) step(op, 1'($urandom));
    end
    step(OP_R, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule